// File: doc/BRIEF.md
# Byte-Wide Calendar Clock Register Front End with Shadow Copy

This block sits on a synchronous byte bus and presents a flat 32K-byte address space. The eight highest addresses are calendar clock registers; every other address reaches a plain byte RAM. The clock keeps two copies of the time. The running counter copy advances once per second. The visible copy is what the bus reads and writes. A small state machine decides when the visible copy follows the counters, when it is held, and when its contents are pushed back into the counters.

Software sets the read bit to take a coherent snapshot of the time, and the counters keep running meanwhile. It sets the write bit to hold the visible copy and load new BCD values. Clearing the write bit commits those values to the counters. Two flags live in the data registers: a stop flag in the seconds byte halts timekeeping, and a test flag in the day byte puts a square wave on the low bit of seconds. A power-fail input blocks every bus access and drives an active-low indication out.

The state machine has four states. RUN: the visible copy tracks the counters. HOLD: the read bit is set and the visible copy is held. SET: the write bit is set and field writes are accepted. COMMIT: a single cycle that loads the counters from the visible copy. The transitions are:
- RUN->HOLD on read-bit set; RUN->SET on write-bit set.
- HOLD->SET on write-bit set; HOLD->RUN on read-bit clear.
- SET->COMMIT on write-bit clear.
- COMMIT->SET if the write bit is set again; COMMIT->HOLD if the read bit is 1; COMMIT->RUN otherwise.

Top module: `rtc_shadow_regs`

## Requirements
- R1: Offsets 0 to 7 of the top eight addresses (0x7FF8 to 0x7FFF) are, in order: control, seconds, minutes, hours, day of week, day of month, month, year. All lower addresses are RAM and return the last byte written. Read data appears on `rd_data` in the cycle after the read; in any other cycle `rd_data` is 0x00.
- R2: After reset the time reads 00:00:00, day 01, date 01, month 01, year 00. The control byte reads 0x00 and the stop and test flags are clear.
- R3: Setting control bit 6 (read bit) freezes every visible field at the time present on that edge, while the counters keep counting. Clearing the bit refreshes all visible fields from the counters on the next cycle.
- R4: While control bit 7 (write bit) is 1, the visible fields stop following the counters and field writes are stored. When the write bit is 0, writes to the time fields are discarded.
- R5: Clearing the write bit loads the counters from the visible fields and restarts the one-second divider. Counting then resumes from the loaded time.
- R6: With both bits set, the write-bit behaviour wins. If the write bit falls while the read bit stays 1, the counters are loaded and the visible copy stays frozen at the loaded value until the read bit clears.
- R7: Seconds bit 7 is a stop flag that can be written at any time and reads back. While it is 1, neither the counters nor the divider advance.
- R8: Day bit 6 is a test flag that can be written at any time. While it is 1 and the stop flag is 0, bit 0 of a seconds read shows a square wave that changes level 1024 times per second (512 Hz).
- R9: Unused bits read 0 and are not stored. The stored bits are: control 7:6, seconds 7:0, minutes 6:0, hours 5:0, day 6 and 2:0, date 5:0, month 4:0, year 7:0.
- R10: While `pwr_fail` is 1, `pf_n` is 0, reads return 0x00, and writes change neither the RAM nor any register. Timekeeping continues.
- R11: Each second carries BCD seconds into minutes, hours, day of week (1..7), date, month and year. Date limits follow the month. February has 29 days in years divisible by four. Year 99 wraps to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timebase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Access select, active high |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| pwr_fail | input | 1 | Supply out of tolerance, blocks access |
| rd_data | output | 8 | Read data, valid one cycle after the read |
| pf_n | output | 1 | Power-fail indication, active low |

## Verification
Two cases need care because two functions land on one clock edge. In the first, the write bit falls while the read bit stays set. That single control write must both commit the counters and keep the visible copy frozen. The bench loads a distinctive time this way and reads it back unchanged after more than a second, which shows the freeze held. After releasing the read bit, it reads the time one second later, which shows the load reached the counters. In the second case, a write and a read are presented while `pwr_fail` is high. The bench judges this by the read returning zero and by the RAM and control contents reading unchanged once power is back.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

    typedef enum logic [1:0] {
        S_RUN    = 2'd0,
        S_HOLD   = 2'd1,
        S_SET    = 2'd2,
        S_COMMIT = 2'd3
    } sync_state_e;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] mday;
        logic [7:0] wday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } tm_t;

    localparam tm_t TM_RESET = '{year: 8'h00, mon: 8'h01, mday: 8'h01,
                                 wday: 8'h01, hour: 8'h00, min: 8'h00,
                                 sec: 8'h00};

    // Register offsets inside the clock window (order decoded by software)
    localparam logic [2:0] OFF_CTRL = 3'd0;
    localparam logic [2:0] OFF_SEC  = 3'd1;
    localparam logic [2:0] OFF_MIN  = 3'd2;
    localparam logic [2:0] OFF_HOUR = 3'd3;
    localparam logic [2:0] OFF_WDAY = 3'd4;
    localparam logic [2:0] OFF_MDAY = 3'd5;
    localparam logic [2:0] OFF_MON  = 3'd6;
    localparam logic [2:0] OFF_YEAR = 3'd7;

    // Storable bits of each time field
    localparam logic [7:0] MSK_SEC  = 8'h7F;
    localparam logic [7:0] MSK_MIN  = 8'h7F;
    localparam logic [7:0] MSK_HOUR = 8'h3F;
    localparam logic [7:0] MSK_WDAY = 8'h07;
    localparam logic [7:0] MSK_MDAY = 8'h3F;
    localparam logic [7:0] MSK_MON  = 8'h1F;
    localparam logic [7:0] MSK_YEAR = 8'hFF;

    localparam int HALVES_PER_SEC = 1024;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) begin
            r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

    function automatic logic is_leap(input logic [7:0] y);
        logic even_tens;
        even_tens = ~y[4];
        return (even_tens  && (y[3:0] == 4'd0 || y[3:0] == 4'd4 || y[3:0] == 4'd8)) ||
               (!even_tens && (y[3:0] == 4'd2 || y[3:0] == 4'd6));
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] m, input logic leap);
        logic [7:0] r;
        case (m)
            8'h02:                      r = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
    parameter int HALF_CLKS = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic phase,
    output logic sec_tick
);
    import rtc_shadow_pkg::*;

    localparam int CW = (HALF_CLKS > 2) ? $clog2(HALF_CLKS) : 1;
    localparam int HW = $clog2(HALVES_PER_SEC);
    localparam logic [CW-1:0] C_LAST = CW'(HALF_CLKS - 1);
    localparam logic [HW-1:0] H_LAST = HW'(HALVES_PER_SEC - 1);

    logic [CW-1:0] cnt_q;
    logic [HW-1:0] half_q;
    logic          phase_q;
    logic          half_end;

    assign half_end = run && (cnt_q == C_LAST);
    assign sec_tick = half_end && (half_q == H_LAST);
    assign phase    = phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q   <= '0;
            half_q  <= '0;
            phase_q <= 1'b0;
        end else if (run) begin
            if (half_end) begin
                cnt_q   <= '0;
                half_q  <= half_q + HW'(1);
                phase_q <= ~phase_q;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // R7: a stopped divider holds its square-wave level
    a_r7_stop_freezes_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(phase_q));

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 sec_tick,
    input  logic                 load,
    input  rtc_shadow_pkg::tm_t  load_val,
    output rtc_shadow_pkg::tm_t  now
);
    import rtc_shadow_pkg::*;

    tm_t now_q;
    tm_t adv;

    assign now = now_q;

    always_comb begin
        adv = now_q;
        if (now_q.sec >= 8'h59) begin
            adv.sec = 8'h00;
            if (now_q.min >= 8'h59) begin
                adv.min = 8'h00;
                if (now_q.hour >= 8'h23) begin
                    adv.hour = 8'h00;
                    adv.wday = (now_q.wday >= 8'h07) ? 8'h01 : now_q.wday + 8'h01;
                    if (now_q.mday >= month_last(now_q.mon, is_leap(now_q.year))) begin
                        adv.mday = 8'h01;
                        if (now_q.mon >= 8'h12) begin
                            adv.mon  = 8'h01;
                            adv.year = (now_q.year >= 8'h99) ? 8'h00 : bcd_inc(now_q.year);
                        end else begin
                            adv.mon = bcd_inc(now_q.mon);
                        end
                    end else begin
                        adv.mday = bcd_inc(now_q.mday);
                    end
                end else begin
                    adv.hour = bcd_inc(now_q.hour);
                end
            end else begin
                adv.min = bcd_inc(now_q.min);
            end
        end else begin
            adv.sec = bcd_inc(now_q.sec);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q <= TM_RESET;
        end else if (load) begin
            now_q <= load_val;
        end else if (run && sec_tick) begin
            now_q <= adv;
        end
    end

    // R7: no counting while stopped
    a_r7_counters_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(now_q));

endmodule

// File: rtl/rtc_ram.sv
module rtc_ram #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];
    logic [7:0] rdata_q;

    assign rdata = rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            rdata_q <= mem[addr];
        end
    end

endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs #(
    parameter int ADDR_W    = 15,
    parameter int RAM_AW    = 11,
    parameter int HALF_CLKS = 16384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              pwr_fail,
    output logic [7:0]        rd_data,
    output logic              pf_n
);
    import rtc_shadow_pkg::*;

    // ---------------- access decode ----------------
    logic       acc_ok, rd_en, wr_en, is_clk;
    logic [2:0] off;

    assign acc_ok = bus_cs && !pwr_fail;
    assign rd_en  = acc_ok && !bus_we;
    assign wr_en  = acc_ok && bus_we;
    assign is_clk = &bus_addr[ADDR_W-1:3];
    assign off    = bus_addr[2:0];
    assign pf_n   = ~pwr_fail;

    logic ctrl_wr, sec_wr, wday_wr;
    assign ctrl_wr = wr_en && is_clk && (off == OFF_CTRL);
    assign sec_wr  = wr_en && is_clk && (off == OFF_SEC);
    assign wday_wr = wr_en && is_clk && (off == OFF_WDAY);

    // ---------------- control and flag bits ----------------
    logic w_q, r_q, stop_q, ft_q;
    logic w_next, r_next;

    assign w_next = ctrl_wr ? bus_wdata[7] : w_q;
    assign r_next = ctrl_wr ? bus_wdata[6] : r_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q    <= 1'b0;
            r_q    <= 1'b0;
            stop_q <= 1'b0;
            ft_q   <= 1'b0;
        end else begin
            w_q <= w_next;
            r_q <= r_next;
            if (sec_wr) begin
                stop_q <= bus_wdata[7];
            end
            if (wday_wr) begin
                ft_q <= bus_wdata[6];
            end
        end
    end

    // ---------------- synchronisation state machine ----------------
    sync_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN: begin
                if (w_next)      state_d = S_SET;
                else if (r_next) state_d = S_HOLD;
            end
            S_HOLD: begin
                if (w_next)       state_d = S_SET;
                else if (!r_next) state_d = S_RUN;
            end
            S_SET: begin
                if (!w_next) state_d = S_COMMIT;
            end
            S_COMMIT: begin
                if (w_next)      state_d = S_SET;
                else if (r_next) state_d = S_HOLD;
                else             state_d = S_RUN;
            end
        endcase
    end

    // ---------------- state machine outputs ----------------
    logic track, load, accept;

    always_comb begin
        track  = 1'b0;
        load   = 1'b0;
        accept = 1'b0;
        unique case (state_q)
            S_RUN:    track  = 1'b1;
            S_HOLD:   ;
            S_SET:    accept = 1'b1;
            S_COMMIT: load   = 1'b1;
        endcase
    end

    // ---------------- timebase ----------------
    logic phase, sec_tick, run;
    tm_t  now, vis_q;

    assign run = !stop_q;

    rtc_divider #(.HALF_CLKS(HALF_CLKS)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .restart  (load),
        .phase    (phase),
        .sec_tick (sec_tick)
    );

    rtc_timebase u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sec_tick (sec_tick),
        .load     (load),
        .load_val (vis_q),
        .now      (now)
    );

    // ---------------- visible copy ----------------
    logic tm_wr;
    assign tm_wr = wr_en && is_clk && accept;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis_q <= TM_RESET;
        end else if (track) begin
            vis_q <= now;
        end else if (tm_wr) begin
            case (off)
                OFF_SEC:  vis_q.sec  <= bus_wdata & MSK_SEC;
                OFF_MIN:  vis_q.min  <= bus_wdata & MSK_MIN;
                OFF_HOUR: vis_q.hour <= bus_wdata & MSK_HOUR;
                OFF_WDAY: vis_q.wday <= bus_wdata & MSK_WDAY;
                OFF_MDAY: vis_q.mday <= bus_wdata & MSK_MDAY;
                OFF_MON:  vis_q.mon  <= bus_wdata & MSK_MON;
                OFF_YEAR: vis_q.year <= bus_wdata & MSK_YEAR;
                default:  ;
            endcase
        end
    end

    // ---------------- read path ----------------
    logic       ft_live;
    logic [7:0] clk_byte;

    assign ft_live = ft_q && !stop_q;

    always_comb begin
        case (off)
            OFF_CTRL: clk_byte = {w_q, r_q, 6'b0};
            OFF_SEC:  clk_byte = {stop_q, vis_q.sec[6:1], ft_live ? phase : vis_q.sec[0]};
            OFF_MIN:  clk_byte = vis_q.min & MSK_MIN;
            OFF_HOUR: clk_byte = vis_q.hour & MSK_HOUR;
            OFF_WDAY: clk_byte = {1'b0, ft_q, 3'b0, vis_q.wday[2:0]};
            OFF_MDAY: clk_byte = vis_q.mday & MSK_MDAY;
            OFF_MON:  clk_byte = vis_q.mon & MSK_MON;
            default:  clk_byte = vis_q.year & MSK_YEAR;
        endcase
    end

    logic       rd_valid_q, rd_clk_q;
    logic [7:0] clk_q, ram_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_clk_q   <= 1'b0;
            clk_q      <= 8'h00;
        end else begin
            rd_valid_q <= rd_en;
            rd_clk_q   <= rd_en && is_clk;
            if (rd_en && is_clk) begin
                clk_q <= clk_byte;
            end
        end
    end

    rtc_ram #(.AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (wr_en && !is_clk),
        .re    (rd_en && !is_clk),
        .addr  (bus_addr[RAM_AW-1:0]),
        .wdata (bus_wdata),
        .rdata (ram_q)
    );

    assign rd_data = !rd_valid_q ? 8'h00 : (rd_clk_q ? clk_q : ram_q);

    // ---------------- assertions ----------------
    // R3: a held visible copy does not move
    a_r3_hold_is_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD) |=> $stable(vis_q));

    // R5: the commit cycle lands the visible copy in the counters
    a_r5_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COMMIT) |=> (now == $past(vis_q)));

    // R10: blocked accesses return zero
    a_r10_pf_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (rd_data == 8'h00));

    // R9: unused control bits read zero
    a_r9_ctrl_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && is_clk && off == OFF_CTRL) |=> (rd_data[5:0] == 6'b0));

endmodule

// File: tb/rtc_shadow_regs_tb.sv
module rtc_shadow_regs_tb;

    localparam int SEC = 2048; // HALF_CLKS=2 -> 1024 halves * 2 cycles

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs = 1'b0;
    logic        bus_we = 1'b0;
    logic [14:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        pwr_fail = 1'b0;
    logic [7:0]  rd_data;
    logic        pf_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rtc_shadow_regs #(.ADDR_W(15), .RAM_AW(11), .HALF_CLKS(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pwr_fail(pwr_fail),
        .rd_data(rd_data), .pf_n(pf_n)
    );

    localparam logic [14:0] A_CTRL = 15'h7FF8, A_SEC = 15'h7FF9, A_MIN = 15'h7FFA,
                            A_HOUR = 15'h7FFB, A_WDAY = 15'h7FFC, A_MDAY = 15'h7FFD,
                            A_MON = 15'h7FFE, A_YEAR = 15'h7FFF;

    typedef struct packed {
        logic        wr;
        logic [14:0] addr;
        logic [7:0]  data;
        logic [7:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b1, 15'h0000, 8'h5A, 8'h00, 4'd1},  // R1 RAM write
        '{1'b1, 15'h0123, 8'h11, 8'h00, 4'd1},  // R1
        '{1'b1, 15'h7FF7, 8'hC3, 8'h00, 4'd1},  // R1 highest RAM byte
        '{1'b0, 15'h0000, 8'h00, 8'h5A, 4'd1},  // R1 read back
        '{1'b0, 15'h0123, 8'h00, 8'h11, 4'd1},  // R1
        '{1'b0, 15'h7FF7, 8'h00, 8'hC3, 4'd1},  // R1
        '{1'b1, 15'h7FF8, 8'h3F, 8'h00, 4'd9},  // R9 unused control bits
        '{1'b0, 15'h7FF8, 8'h00, 8'h00, 4'd9},  // R9
        '{1'b1, 15'h7FFE, 8'h12, 8'h00, 4'd4},  // R4 month write, write bit 0
        '{1'b0, 15'h7FFE, 8'h00, 8'h01, 4'd4},  // R4 discarded
        '{1'b1, 15'h7FFF, 8'h55, 8'h00, 4'd4},  // R4 year write, write bit 0
        '{1'b0, 15'h7FFF, 8'h00, 8'h00, 4'd4}   // R4 discarded
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [14:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = rd_data;
        bus_cs = 1'b0;
    endtask

    task automatic rd_chk(input logic [14:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] d;
        rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        int ones, zeros;
        wait_cyc(3);
        @(negedge clk) rst_n = 1'b1;

        // R2 reset state
        check("R2 pf_n", {7'b0, pf_n}, 8'h01);
        rd_chk(A_CTRL, 8'h00, "R2 control");
        rd_chk(A_SEC,  8'h00, "R2 seconds");
        rd_chk(A_HOUR, 8'h00, "R2 hours");
        rd_chk(A_WDAY, 8'h01, "R2 day");
        rd_chk(A_MDAY, 8'h01, "R2 date");
        rd_chk(A_MON,  8'h01, "R2 month");
        rd_chk(A_YEAR, 8'h00, "R2 year");
        check("R1 idle rd_data", rd_data, 8'h00);

        // vector table
        for (int i = 0; i < 12; i++) begin
            if (VECS[i].wr) begin
                wr(VECS[i].addr, VECS[i].data);
            end else begin
                rd(VECS[i].addr, d);
                check($sformatf("R%0d vector %0d", VECS[i].req, i), d, VECS[i].exp);
            end
        end

        // R4/R5/R11: load 23:59:58 on 28 Feb of a leap year
        wr(A_CTRL, 8'h80);
        wr(A_SEC, 8'h58); wr(A_MIN, 8'h59); wr(A_HOUR, 8'h23); wr(A_WDAY, 8'h07);
        wr(A_MDAY, 8'h28); wr(A_MON, 8'h02); wr(A_YEAR, 8'h24);
        wait_cyc(3000);
        rd_chk(A_SEC, 8'h58, "R4 held while setting");
        rd_chk(A_CTRL, 8'h80, "R1 control write bit");
        wr(A_CTRL, 8'h00);
        wait_cyc(SEC * 5 / 2);
        wr(A_CTRL, 8'h40);
        rd_chk(A_SEC,  8'h00, "R5 seconds after commit");
        rd_chk(A_MIN,  8'h00, "R11 minutes carry");
        rd_chk(A_HOUR, 8'h00, "R11 hours carry");
        rd_chk(A_WDAY, 8'h01, "R11 day of week wrap");
        rd_chk(A_MDAY, 8'h29, "R11 leap date");
        rd_chk(A_MON,  8'h02, "R11 leap month");
        wr(A_CTRL, 8'h00);

        // R11: non-leap February end and month carry
        wr(A_CTRL, 8'h80);
        wr(A_SEC, 8'h59); wr(A_MIN, 8'h59); wr(A_HOUR, 8'h23); wr(A_WDAY, 8'h03);
        wr(A_MDAY, 8'h28); wr(A_MON, 8'h02); wr(A_YEAR, 8'h23);
        wr(A_CTRL, 8'h00);
        wait_cyc(SEC * 3 / 2);
        wr(A_CTRL, 8'h40);
        rd_chk(A_MDAY, 8'h01, "R11 non-leap date");
        rd_chk(A_MON,  8'h03, "R11 non-leap month");
        rd_chk(A_WDAY, 8'h04, "R11 day of week");
        wr(A_CTRL, 8'h00);

        // R3: freeze while counters run
        wr(A_CTRL, 8'h80);
        wr(A_SEC, 8'h10);
        wr(A_CTRL, 8'h00);
        wr(A_CTRL, 8'h40);
        wait_cyc(SEC * 16 / 5);
        rd_chk(A_SEC, 8'h10, "R3 frozen seconds");
        wr(A_CTRL, 8'h00);
        rd_chk(A_SEC, 8'h13, "R3 refreshed seconds");

        // R6: write bit falls while read bit stays set
        wr(A_CTRL, 8'hC0);
        wr(A_SEC, 8'h40); wr(A_MIN, 8'h05);
        wr(A_CTRL, 8'h40);
        wait_cyc(SEC * 3 / 2);
        rd_chk(A_SEC, 8'h40, "R6 frozen at loaded value");
        rd_chk(A_MIN, 8'h05, "R6 loaded minutes");
        rd_chk(A_CTRL, 8'h40, "R6 control read bit");
        wr(A_CTRL, 8'h00);
        rd_chk(A_SEC, 8'h41, "R6 counters were loaded");

        // R7: stop flag
        wr(A_CTRL, 8'h80);
        wr(A_SEC, 8'h20);
        wr(A_CTRL, 8'h00);
        wr(A_SEC, 8'h80);
        rd_chk(A_SEC, 8'hA0, "R7 stop readback");
        wait_cyc(SEC * 5 / 2);
        rd_chk(A_SEC, 8'hA0, "R7 stopped time");

        // R8: test flag with stop set gives no toggling
        wr(A_WDAY, 8'h40);
        ones = 0; zeros = 0;
        for (int k = 0; k < 8; k++) begin
            rd(A_SEC, d);
            if (d[0]) ones++; else zeros++;
        end
        check("R8 no toggle while stopped", 8'(ones), 8'd0);

        // R8: running with test flag
        wr(A_SEC, 8'h00);
        ones = 0; zeros = 0;
        for (int k = 0; k < 8; k++) begin
            rd(A_SEC, d);
            if (d[0]) ones++; else zeros++;
            check("R8 upper seconds bits", d & 8'hFE, 8'h20);
        end
        check("R8 toggle high seen", 8'(ones > 0), 8'd1);
        check("R8 toggle low seen", 8'(zeros > 0), 8'd1);
        rd_chk(A_WDAY, 8'h44, "R8 day with test flag");
        wr(A_WDAY, 8'h00);
        rd_chk(A_WDAY, 8'h04, "R8 test flag cleared, day kept");

        // R10: power fail blocks access
        @(negedge clk) pwr_fail = 1'b1;
        @(negedge clk);
        check("R10 pf_n low", {7'b0, pf_n}, 8'h00);
        wr(15'h0123, 8'hEE);
        wr(A_CTRL, 8'h80);
        rd_chk(15'h0123, 8'h00, "R10 read blocked");
        @(negedge clk) pwr_fail = 1'b0;
        @(negedge clk);
        check("R10 pf_n high", {7'b0, pf_n}, 8'h01);
        rd_chk(15'h0123, 8'h11, "R10 RAM unchanged");
        rd_chk(A_CTRL, 8'h00, "R10 control unchanged");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule